// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block watches a small set of external interrupt pins and turns activity on them into interrupt requests. Each pin has its own 2-bit sense field. The field selects one of three triggers: a low level, a falling edge or a rising edge. A fourth code is reserved and raises nothing. The pin value is sampled whatever the pin's direction, so firmware that drives a pin configured as an output can raise an interrupt in software.

In the two edge modes, a detected transition sets a per-pin flag. The flag holds until the interrupt vector is acknowledged or software writes a one to clear it. In low-level mode nothing is latched. The request follows the synchronized pin and disappears as soon as the pin returns high, whether or not the request was serviced.

A request leaves the block only when three things hold together: the pin's trigger condition, the pin's own enable and the global enable. Pin drivers and arbitration between vectors sit outside the block.

Top module: `extirq_detect`

## Requirements
- R1: After reset, with all pins held high, every flag and every request reads 0.
- R2: With sense code 00 (low level), the request of an enabled pin is high from the second rising clock edge after the pin goes low, and for as long as the pin stays low. No flag is set.
- R3: A low-level request is not remembered. Two rising edges after the pin returns high, the request is 0 again even if it was never acknowledged.
- R4: With sense code 10 (falling edge), a high-to-low transition sets the pin's flag on the third rising edge after the change. The flag and the request then persist after the pin returns high.
- R5: With sense code 11 (rising edge), a low-to-high transition sets the flag. A high-to-low transition does not.
- R6: Sense code 01 is reserved. It never sets a flag and never produces a request.
- R7: An acknowledge pulse for a pin clears that pin's flag on the same clock edge.
- R8: A one written to a pin's clear input clears that pin's flag on the same clock edge.
- R9: A request is output only while both the global enable and the pin's enable are high. A flag still latches while its request is disabled, and its request appears once the enables return.
- R10: When a new edge is detected on the same edge as an acknowledge or a clear, the flag ends up set, so the new event is not lost.
- R11: Pins are independent. Activity on one pin never changes another pin's flag or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_PINS | Raw pin values, read regardless of pin direction |
| senseMode | input | 2*NUM_PINS | Two-bit sense code per pin; pin i uses bits [2i+1:2i] |
| pinEnable | input | NUM_PINS | Per-pin request enable |
| globalEnable | input | 1 | Global interrupt enable |
| ackIn | input | NUM_PINS | Vector-acknowledge pulse per pin |
| clearWrite | input | NUM_PINS | Write-one-to-clear strobe per pin flag |
| irqReq | output | NUM_PINS | Interrupt request per pin |
| flagOut | output | NUM_PINS | Latched edge flag per pin |

## Verification
The pin passes through two synchronizer registers, so a level request is due two rising edges after the pin changes. An edge flag needs one more register and is due on the third. Acknowledge and clear strobes, and the enables, act on the very next edge or at once. The bench drives inputs on falling edges and samples on falling edges. It checks each level result at exactly the second falling edge after the stimulus and each flag at the third. The set-versus-clear race is staged by asserting the acknowledge in the one cycle where the detected edge is due.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  // control -> datapath strobes, one per pin
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic levelHit;
  } pinStrobe_t;

endpackage

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 2
) (
  input  logic [2*NUM_PINS-1:0] senseMode,
  input  logic [NUM_PINS-1:0]   syncVal,
  input  logic [NUM_PINS-1:0]   prevVal,
  input  logic [NUM_PINS-1:0]   ackIn,
  input  logic [NUM_PINS-1:0]   clearWrite,
  output pinStrobe_t [NUM_PINS-1:0] strobe
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    senseMode_e mode;
    logic fell;
    logic rose;

    assign mode = senseMode_e'(senseMode[2*i +: 2]);
    assign fell = prevVal[i] & ~syncVal[i];
    assign rose = ~prevVal[i] & syncVal[i];

    assign strobe[i].setFlag  = ((mode == SENSE_FALL) & fell) |
                                ((mode == SENSE_RISE) & rose);
    assign strobe[i].clrFlag  = ackIn[i] | clearWrite[i];
    assign strobe[i].levelHit = (mode == SENSE_LOW) & ~syncVal[i];
  end

endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PINS-1:0]     pinIn,
  input  logic [NUM_PINS-1:0]     pinEnable,
  input  logic                    globalEnable,
  input  pinStrobe_t [NUM_PINS-1:0] strobe,
  output logic [NUM_PINS-1:0]     syncVal,
  output logic [NUM_PINS-1:0]     prevVal,
  output logic [NUM_PINS-1:0]     flagOut,
  output logic [NUM_PINS-1:0]     irqReq
);

  localparam int SyncMsb = SYNC_STAGES - 1;

  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    logic [SYNC_STAGES-1:0] chain;
    logic prevBit;
    logic flagBit;

    // idle-high reset so a quiet pin raises no edge after reset
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain   <= '1;
        prevBit <= 1'b1;
        flagBit <= 1'b0;
      end else begin
        chain   <= (chain << 1) | SYNC_STAGES'(pinIn[i]);
        prevBit <= chain[SyncMsb];
        // a fresh edge wins over a clear in the same cycle
        flagBit <= strobe[i].setFlag | (flagBit & ~strobe[i].clrFlag);
      end
    end

    assign syncVal[i] = chain[SyncMsb];
    assign prevVal[i] = prevBit;
    assign flagOut[i] = flagBit;
    assign irqReq[i]  = globalEnable & pinEnable[i] &
                        (flagBit | strobe[i].levelHit);
  end

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [2*NUM_PINS-1:0] senseMode,
  input  logic [NUM_PINS-1:0]   pinEnable,
  input  logic                  globalEnable,
  input  logic [NUM_PINS-1:0]   ackIn,
  input  logic [NUM_PINS-1:0]   clearWrite,
  output logic [NUM_PINS-1:0]   irqReq,
  output logic [NUM_PINS-1:0]   flagOut
);

  pinStrobe_t [NUM_PINS-1:0] strobe;
  logic [NUM_PINS-1:0] syncVal;
  logic [NUM_PINS-1:0] prevVal;

  extirq_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .senseMode  (senseMode),
    .syncVal    (syncVal),
    .prevVal    (prevVal),
    .ackIn      (ackIn),
    .clearWrite (clearWrite),
    .strobe     (strobe)
  );

  extirq_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pinIn        (pinIn),
    .pinEnable    (pinEnable),
    .globalEnable (globalEnable),
    .strobe       (strobe),
    .syncVal      (syncVal),
    .prevVal      (prevVal),
    .flagOut      (flagOut),
    .irqReq       (irqReq)
  );

endmodule

// File: rtl/extirq_checker.sv
module extirq_checker #(
  parameter int NUM_PINS = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [2*NUM_PINS-1:0] senseMode,
  input logic [NUM_PINS-1:0]   pinEnable,
  input logic                  globalEnable,
  input logic [NUM_PINS-1:0]   ackIn,
  input logic [NUM_PINS-1:0]   clearWrite,
  input logic [NUM_PINS-1:0]   irqReq,
  input logic [NUM_PINS-1:0]   flagOut,
  input logic [NUM_PINS-1:0]   syncVal,
  input logic [NUM_PINS-1:0]   prevVal
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : gChk
    logic [1:0] m;
    logic edgeSeen;
    assign m = senseMode[2*i +: 2];
    assign edgeSeen = (m == 2'b10 && prevVal[i] && !syncVal[i]) ||
                      (m == 2'b11 && !prevVal[i] && syncVal[i]);

    assert_fall_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
      (m == 2'b10 && prevVal[i] && !syncVal[i]) |=> flagOut[i]);

    assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
      (m == 2'b11 && !prevVal[i] && syncVal[i]) |=> flagOut[i]);

    assert_level_req_R2: assert property (@(posedge clk) disable iff (!rstN)
      (m == 2'b00 && !syncVal[i] && pinEnable[i] && globalEnable) |-> irqReq[i]);

    assert_rsvd_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
      (m == 2'b01 && !flagOut[i]) |-> !irqReq[i]);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
      (ackIn[i] && !edgeSeen) |=> !flagOut[i]);

    assert_wc_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
      (clearWrite[i] && !edgeSeen) |=> !flagOut[i]);

    assert_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!globalEnable || !pinEnable[i]) |-> !irqReq[i]);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      (edgeSeen && (ackIn[i] || clearWrite[i])) |=> flagOut[i]);

    assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!edgeSeen && !ackIn[i] && !clearWrite[i]) |=> $stable(flagOut[i]));
  end

endmodule

bind extirq_detect extirq_checker #(.NUM_PINS(NUM_PINS)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .senseMode    (senseMode),
  .pinEnable    (pinEnable),
  .globalEnable (globalEnable),
  .ackIn        (ackIn),
  .clearWrite   (clearWrite),
  .irqReq       (irqReq),
  .flagOut      (flagOut),
  .syncVal      (syncVal),
  .prevVal      (prevVal)
);

// File: tb/extirq_detect_bench.sv
module extirq_detect_bench;

  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] pinIn;
  logic [2*N-1:0] senseMode;
  logic [N-1:0] pinEnable;
  logic         globalEnable;
  logic [N-1:0] ackIn;
  logic [N-1:0] clearWrite;
  logic [N-1:0] irqReq;
  logic [N-1:0] flagOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  extirq_detect #(.NUM_PINS(N), .SYNC_STAGES(2)) u_extirq_detect (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .senseMode(senseMode),
    .pinEnable(pinEnable), .globalEnable(globalEnable), .ackIn(ackIn),
    .clearWrite(clearWrite), .irqReq(irqReq), .flagOut(flagOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    clearWrite = '1;
    waitN(1);
    clearWrite = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pinIn = '1; senseMode = '0; pinEnable = '1;
    globalEnable = 1'b1; ackIn = '0; clearWrite = '0;
    waitN(3);
    rstN = 1'b1;
    waitN(3);
    // R1: reset state (mode 00, pins high -> no level request)
    check("R1 flags", int'(flagOut), 0);
    check("R1 requests", int'(irqReq), 0);

    // sweep every pin and every sense code; the other pin is set to falling edge
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 4; m++) begin
        int o;
        o = 1 - p;
        senseMode[2*p +: 2] = 2'(m);
        senseMode[2*o +: 2] = 2'b10;
        waitN(2);
        clearAll();
        pinIn[p] = 1'b0;
        waitN(2);
        // R2 / R6: level request due two edges after the pin falls
        check(m == 0 ? "R2 level request" : "R6 no early request",
              int'(irqReq[p]), (m == 0) ? 1 : 0);
        waitN(1);
        check(m == 2 ? "R4 fall flag" : "R2 R5 R6 no flag on fall",
              int'(flagOut[p]), (m == 2) ? 1 : 0);
        check("R2 request held while low",
              int'(irqReq[p]), (m == 0 || m == 2) ? 1 : 0);
        pinIn[p] = 1'b1;
        waitN(3);
        check(m == 3 ? "R5 rise flag" : "R3 R4 R6 flag after rise",
              int'(flagOut[p]), (m == 2 || m == 3) ? 1 : 0);
        check("R3 R4 request after rise",
              int'(irqReq[p]), (m == 2 || m == 3) ? 1 : 0);
        check("R11 other pin flag", int'(flagOut[o]), 0);
        check("R11 other pin request", int'(irqReq[o]), 0);
        clearWrite[p] = 1'b1;
        waitN(1);
        clearWrite[p] = 1'b0;
        check("R8 write-one clear", int'(flagOut[p]), 0);
        check("R8 request gone", int'(irqReq[p]), 0);
      end
    end

    // R7: acknowledge clears
    senseMode = {2'b10, 2'b10};
    clearAll();
    pinIn[0] = 1'b0; waitN(3); pinIn[0] = 1'b1;
    check("R7 flag before ack", int'(flagOut[0]), 1);
    waitN(2);
    ackIn[0] = 1'b1; waitN(1); ackIn[0] = 1'b0;
    check("R7 ack clears flag", int'(flagOut[0]), 0);
    waitN(2);

    // R9: gating by global and per-pin enable
    globalEnable = 1'b0;
    pinIn[1] = 1'b0; waitN(3); pinIn[1] = 1'b1;
    check("R9 flag latches while disabled", int'(flagOut[1]), 1);
    check("R9 no request while global off", int'(irqReq[1]), 0);
    globalEnable = 1'b1; waitN(1);
    check("R9 request after enable", int'(irqReq[1]), 1);
    pinEnable[1] = 1'b0; waitN(1);
    check("R9 pin enable off", int'(irqReq[1]), 0);
    pinEnable[1] = 1'b1;
    senseMode[1:0] = 2'b00;
    pinIn[0] = 1'b0; waitN(2);
    globalEnable = 1'b0; waitN(1);
    check("R9 level gated by global", int'(irqReq[0]), 0);
    globalEnable = 1'b1; pinIn[0] = 1'b1; senseMode[1:0] = 2'b10;
    waitN(3);
    clearAll();

    // R10: edge detected in the same cycle as an acknowledge
    pinIn[0] = 1'b0;
    waitN(2);
    ackIn[0] = 1'b1;
    waitN(1);
    ackIn[0] = 1'b0;
    check("R10 set wins over ack", int'(flagOut[0]), 1);
    pinIn[0] = 1'b1;
    waitN(3);
    clearAll();
    pinIn[0] = 1'b0;
    waitN(2);
    clearWrite[0] = 1'b1;
    waitN(1);
    clearWrite[0] = 1'b0;
    check("R10 set wins over clear", int'(flagOut[0]), 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule